// File: doc/BRIEF.md
# Dual-Rail Null-Convention Register Stage

This block is one register stage of a null-convention (clockless-protocol) pipeline. It sits between an upstream and a downstream dual-rail logic block. Each bit travels on two rails: true rail high means 1, false rail high means 0, both low is the empty (NULL) spacer. The stage holds each rail with a 2-of-2 hysteresis gate. One input of the gate is the upstream rail. The other is the request line coming back from the next stage.

A completion detector watches every output pair. It drives the request line back to the previous stage. That line goes low once a full DATA wavefront has been captured, and high once a full NULL wavefront has been captured. Stages are chained by wiring each stage's `dn_req` to the next stage's `up_req`, so DATA and NULL wavefronts alternate through the pipeline under a four-phase handshake.

The model is cycle-based. Every hysteresis gate and the completion element is a register updated on `clk`, with synchronous active-high reset.

Top module: `ncl_reg_stage`

## Requirements
- R1: While reset is applied and on the first cycle after it, every output rail is 0 (all pairs NULL) and `up_req` is 1 (DATA requested from upstream).
- R2: An output rail changes 0→1 only on a clock edge where its upstream rail and `dn_req` were both 1. A level of 1 on `dn_req` requests DATA.
- R3: An output rail changes 1→0 only on a clock edge where its upstream rail and `dn_req` were both 0. A level of 0 on `dn_req` requests NULL.
- R4: On an edge where a rail's upstream value differs from `dn_req`, that output rail keeps its value (hysteresis).
- R5: When every output pair holds DATA (exactly one rail high: true=1/false=0 is value 1, true=0/false=1 is value 0), `up_req` is 0 one cycle later.
- R6: When every output rail is 0, `up_req` is 1 one cycle later.
- R7: When only some pairs hold DATA and the others are NULL, `up_req` keeps its previous value.
- R8: In a chain of stages with randomly timed consumer requests, DATA tokens arrive in the order sent, none lost or duplicated, and each DATA wavefront is separated from the next by a full NULL wavefront.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Evaluation clock of the cycle-based model |
| rst | input | 1 | Synchronous active-high reset |
| up_t | input | W | True rails from the upstream block |
| up_f | input | W | False rails from the upstream block |
| dn_req | input | 1 | Request from the next stage: 1 asks for DATA, 0 asks for NULL |
| dn_t | output | W | Registered true rails toward the next stage |
| dn_f | output | W | Registered false rails toward the next stage |
| up_req | output | 1 | Request toward the previous stage: inverse of output completion |

## Verification
A narrow two-pair instance is swept over every combination of stored pair codes, applied pair codes and request level. This separates the rise-only-on-agreement rule from the fall-only-on-agreement rule and from holding. Directed steps drive full DATA, full NULL and mixed wavefronts. They show that the backward request moves one cycle after a complete wavefront and stays put on a mixed one. A three-stage chain then carries every 4-bit value twice under a randomly paced consumer. This exposes token reordering, loss, duplication or a missing NULL spacer.

// File: rtl/ncl_pkg.sv
package ncl_pkg;

    // Wavefront seen at a completion point
    typedef enum logic [1:0] {
        WF_MIXED = 2'b00,
        WF_NULL  = 2'b01,
        WF_DATA  = 2'b10
    } wavefront_e;

    typedef struct packed {
        logic all_data;
        logic all_null;
    } cmpl_t;

    // 2-of-2 hysteresis gate: rise on both high, fall on both low, else hold
    function automatic logic th22_next(logic a, logic b, logic q);
        if (a && b)
            return 1'b1;
        else if (!a && !b)
            return 1'b0;
        else
            return q;
    endfunction

    function automatic wavefront_e classify(cmpl_t c);
        if (c.all_data)
            return WF_DATA;
        else if (c.all_null)
            return WF_NULL;
        else
            return WF_MIXED;
    endfunction

endpackage

// File: rtl/ncl_th22_bank.sv
module ncl_th22_bank
    import ncl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rail_in,
    input  logic         gate_req,
    output logic [W-1:0] rail_q
);

    for (genvar i = 0; i < W; i++) begin : g_gate
        logic held;
        always_ff @(posedge clk) begin
            if (rst)
                held <= 1'b0;
            else
                held <= th22_next(rail_in[i], gate_req, held);
        end
        assign rail_q[i] = held;
    end

endmodule

// File: rtl/ncl_completion.sv
module ncl_completion
    import ncl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] t_rail,
    input  logic [W-1:0] f_rail,
    output logic         done
);

    localparam int PAIRS = W;

    logic [PAIRS-1:0] pair_data;
    logic [PAIRS-1:0] pair_null;
    cmpl_t            cmpl;
    wavefront_e       wf;
    logic             done_q;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_data[p] = t_rail[p] ^ f_rail[p];
        assign pair_null[p] = ~(t_rail[p] | f_rail[p]);
    end

    assign cmpl.all_data = &pair_data;
    assign cmpl.all_null = &pair_null;
    assign wf            = classify(cmpl);

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else begin
            case (wf)
                WF_DATA: done_q <= 1'b1;
                WF_NULL: done_q <= 1'b0;
                default: done_q <= done_q;
            endcase
        end
    end

    assign done = done_q;

endmodule

// File: rtl/ncl_reg_stage.sv
module ncl_reg_stage
    import ncl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] up_t,
    input  logic [W-1:0] up_f,
    input  logic         dn_req,
    output logic [W-1:0] dn_t,
    output logic [W-1:0] dn_f,
    output logic         up_req
);

    logic done;

    ncl_th22_bank #(.W(W)) u_true_bank (
        .clk      (clk),
        .rst      (rst),
        .rail_in  (up_t),
        .gate_req (dn_req),
        .rail_q   (dn_t)
    );

    ncl_th22_bank #(.W(W)) u_false_bank (
        .clk      (clk),
        .rst      (rst),
        .rail_in  (up_f),
        .gate_req (dn_req),
        .rail_q   (dn_f)
    );

    ncl_completion #(.W(W)) u_cmpl (
        .clk    (clk),
        .rst    (rst),
        .t_rail (dn_t),
        .f_rail (dn_f),
        .done   (done)
    );

    assign up_req = ~done;

endmodule

// File: rtl/ncl_reg_stage_chk.sv
module ncl_reg_stage_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] up_t,
    input logic [W-1:0] up_f,
    input logic         dn_req,
    input logic [W-1:0] dn_t,
    input logic [W-1:0] dn_f,
    input logic         up_req
);

    localparam int R2W = 2 * W;

    logic [R2W-1:0] q_all;
    logic [R2W-1:0] in_all;
    logic           full_data;
    logic           full_null;

    assign q_all     = {dn_t, dn_f};
    assign in_all    = {up_t, up_f};
    assign full_data = &(dn_t ^ dn_f);
    assign full_null = ~|(dn_t | dn_f);

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (dn_t == '0 && dn_f == '0 && up_req));

    p_rise_r2: assert property (@(posedge clk) disable iff (rst)
        ((q_all & ~$past(q_all)) & ~($past(in_all) & {R2W{$past(dn_req)}})) == '0);

    p_fall_r3: assert property (@(posedge clk) disable iff (rst)
        ((~q_all & $past(q_all)) & ~(~$past(in_all) & ~{R2W{$past(dn_req)}})) == '0);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ((q_all ^ $past(q_all)) & ($past(in_all) ^ {R2W{$past(dn_req)}})) == '0);

    p_ack_data_r5: assert property (@(posedge clk) disable iff (rst)
        full_data |=> !up_req);

    p_ack_null_r6: assert property (@(posedge clk) disable iff (rst)
        full_null |=> up_req);

    p_ack_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!full_data && !full_null) |=> $stable(up_req));

endmodule

bind ncl_reg_stage ncl_reg_stage_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .up_t   (up_t),
    .up_f   (up_f),
    .dn_req (dn_req),
    .dn_t   (dn_t),
    .dn_f   (dn_f),
    .up_req (up_req)
);

// File: tb/sim_ncl_reg_stage.sv
module sim_ncl_reg_stage;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 2;
    localparam int CW = 4;
    localparam int NTOK = 32;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Single narrow stage
    logic [SW-1:0] s_it = '0, s_if = '0, s_qt, s_qf;
    logic          s_ki = 1'b0, s_ko;

    ncl_reg_stage #(.W(SW)) u0 (
        .clk(clk), .rst(rst), .up_t(s_it), .up_f(s_if), .dn_req(s_ki),
        .dn_t(s_qt), .dn_f(s_qf), .up_req(s_ko)
    );

    // Three-stage chain
    logic [CW-1:0] p_t = '0, p_f = '0;
    logic [CW-1:0] a_t, a_f, b_t, b_f, c_t, c_f;
    logic          ko1, ko2, ko3;
    logic          cons_ki = 1'b0;

    ncl_reg_stage #(.W(CW)) u1 (
        .clk(clk), .rst(rst), .up_t(p_t), .up_f(p_f), .dn_req(ko2),
        .dn_t(a_t), .dn_f(a_f), .up_req(ko1)
    );
    ncl_reg_stage #(.W(CW)) u2 (
        .clk(clk), .rst(rst), .up_t(a_t), .up_f(a_f), .dn_req(ko3),
        .dn_t(b_t), .dn_f(b_f), .up_req(ko2)
    );
    ncl_reg_stage #(.W(CW)) u3 (
        .clk(clk), .rst(rst), .up_t(b_t), .up_f(b_f), .dn_req(cons_ki),
        .dn_t(c_t), .dn_f(c_f), .up_req(ko3)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // pair code: 0 = NULL, 1 = value 1 (true rail), 2 = value 0 (false rail)
    function automatic logic [1:0] pair_rails(int code);
        return (code == 1) ? 2'b10 : (code == 2) ? 2'b01 : 2'b00;
    endfunction

    task automatic set_codes(input int c1, input int c0,
                             output logic [SW-1:0] t, output logic [SW-1:0] f);
        logic [1:0] r1, r0;
        r1 = pair_rails(c1);
        r0 = pair_rails(c0);
        t = {r1[1], r0[1]};
        f = {r1[0], r0[0]};
    endtask

    task automatic single_stage_tests();
        logic [SW-1:0] pt, pf, nt, nf, et, ef;
        // R1 reset state
        check(s_qt == '0 && s_qf == '0, "R1 outputs NULL after reset", {s_qt, s_qf}, 0);
        check(s_ko == 1'b1, "R1 requests DATA after reset", s_ko, 1);

        // R2: data present but NULL requested -> no rise
        s_it = 2'b01; s_if = 2'b10; s_ki = 1'b0;
        tick();
        check(s_qt == '0 && s_qf == '0, "R2 no rise while dn_req low", {s_qt, s_qf}, 0);
        s_ki = 1'b1;
        tick();
        check(s_qt == 2'b01 && s_qf == 2'b10, "R2 capture DATA", {s_qt, s_qf}, 6);
        check(s_ko == 1'b1, "R5 ack not yet moved", s_ko, 1);
        tick();
        check(s_ko == 1'b0, "R5 ack low after full DATA", s_ko, 0);

        // R4: NULL upstream while DATA still requested -> hold
        s_it = '0; s_if = '0;
        tick(); tick();
        check(s_qt == 2'b01 && s_qf == 2'b10, "R4 hold while rails disagree", {s_qt, s_qf}, 6);
        check(s_ko == 1'b0, "R4 ack unchanged", s_ko, 0);

        // R7: mixed wavefront from ack low
        s_ki = 1'b0; s_it = 2'b00; s_if = 2'b10;
        tick();
        check(s_qt == 2'b00 && s_qf == 2'b10, "R3 pair0 falls", {s_qt, s_qf}, 2);
        tick();
        check(s_ko == 1'b0, "R7 ack held on mixed wavefront", s_ko, 0);

        // R6: full NULL
        s_if = 2'b00;
        tick();
        check(s_qt == '0 && s_qf == '0, "R3 all fall", {s_qt, s_qf}, 0);
        tick();
        check(s_ko == 1'b1, "R6 ack high after full NULL", s_ko, 1);

        // R7: mixed wavefront from ack high
        s_ki = 1'b1; s_it = 2'b01; s_if = 2'b00;
        tick(); tick();
        check(s_qt == 2'b01 && s_qf == 2'b00, "R2 partial capture", {s_qt, s_qf}, 4);
        check(s_ko == 1'b1, "R7 ack held on partial DATA", s_ko, 1);

        // Exhaustive sweep: stored codes x applied codes x request
        for (int p1 = 0; p1 < 3; p1++)
        for (int p0 = 0; p0 < 3; p0++)
        for (int n1 = 0; n1 < 3; n1++)
        for (int n0 = 0; n0 < 3; n0++)
        for (int k = 0; k < 2; k++) begin
            s_it = '0; s_if = '0; s_ki = 1'b0;
            tick();
            set_codes(p1, p0, pt, pf);
            s_it = pt; s_if = pf; s_ki = 1'b1;
            tick();
            set_codes(n1, n0, nt, nf);
            s_it = nt; s_if = nf; s_ki = k[0];
            tick();
            // rises where input and request both high, falls where both low
            et = k[0] ? (pt | nt) : (pt & nt);
            ef = k[0] ? (pf | nf) : (pf & nf);
            check(s_qt == et && s_qf == ef, "R2 R3 R4 sweep", {s_qt, s_qf}, {et, ef});
        end
        s_it = '0; s_if = '0; s_ki = 1'b0;
        tick();
    endtask

    // Chain producer / consumer
    int  recv_count = 0;
    bit  prod_done = 1'b0;

    task automatic producer();
        for (int n = 0; n < NTOK; n++) begin
            logic [CW-1:0] v;
            v = CW'(n % (1 << CW));
            while (!ko1) @(negedge clk);
            repeat ($urandom_range(0, 2)) @(negedge clk);
            p_t = v; p_f = ~v;
            @(negedge clk);
            while (ko1) @(negedge clk);
            p_t = '0; p_f = '0;
            @(negedge clk);
        end
        prod_done = 1'b1;
    endtask

    task automatic consumer();
        bit saw_null = 1'b1;
        for (int n = 0; n < NTOK; n++) begin
            logic [CW-1:0] exp_v;
            exp_v = CW'(n % (1 << CW));
            repeat ($urandom_range(0, 5)) @(negedge clk);
            cons_ki = 1'b1;
            while (!(&(c_t ^ c_f))) @(negedge clk);
            check(c_t == exp_v, "R8 token order", c_t, exp_v);
            check(saw_null, "R8 NULL before DATA", saw_null, 1);
            saw_null = 1'b0;
            recv_count++;
            repeat ($urandom_range(0, 5)) @(negedge clk);
            cons_ki = 1'b0;
            while ((c_t | c_f) != '0) @(negedge clk);
            saw_null = 1'b1;
        end
    endtask

    // R8: a DATA wavefront never changes value without an intervening NULL
    logic [CW-1:0] last_val = '0;
    bit            last_full = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (&(c_t ^ c_f)) begin
                if (last_full && c_t != last_val) begin
                    checks++;
                    errors++;
                    $display("FAIL R8 DATA without NULL spacer actual=%0h expected=%0h",
                             c_t, last_val);
                end
                last_full = 1'b1;
                last_val  = c_t;
            end else if ((c_t | c_f) == '0) begin
                last_full = 1'b0;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", recv_count, NTOK);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(ko1 && a_t == '0 && a_f == '0, "R1 chain stage reset", ko1, 1);
        single_stage_tests();
        fork
            producer();
            consumer();
        join
        check(recv_count == NTOK, "R8 no tokens lost", recv_count, NTOK);
        repeat (10) @(negedge clk);
        check((c_t | c_f) == '0 && cons_ki == 1'b0, "R8 chain drains to NULL", {c_t, c_f}, 0);
        check(prod_done, "R8 producer finished", prod_done, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule